// File: doc/BRIEF.md
# Reversible Contrast-Map Pixel Pair Embedder

This block hides a serial stream of watermark bits inside a stream of 8-bit gray-level pixel pairs so that a later decoder can recover both the payload and the exact original picture. Each pair (x, y) goes through an integer contrast map, x' = 2x − y and y' = 2y − x. The map is applied only when both results stay within the gray-level range [0, 255]. For a pair inside that range, one payload bit goes into the least-significant bit of y', and the least-significant bit of x' records which branch was taken. Pairs in which both values are odd take the branch that clears that bit. Pairs in which at least one value is even take the branch that sets it.

A pair outside the range leaves the block unchanged, except that the least-significant bit of x is cleared. The original bit is then emitted on a side output so it can be stored as auxiliary data. A per-pair flag tells whether the pair was transformed, and this flag can feed a location map. Watermark bits arrive on their own valid/ready stream and are taken only for pairs that actually carry one.

The block is a three-stage pipeline that accepts one pair per clock. Backpressure from the output, or a missing watermark bit for a pair that needs one, stalls the pipeline without losing or repeating any pair.

Top module: `rcm_pair_embed`

## Requirements
- R1: For a transformable pair, bits 7..1 of out_x equal bits 7..1 of 2x − y, and bits 7..1 of out_y equal bits 7..1 of 2y − x.
- R2: A pair is transformable exactly when both 2x − y and 2y − x lie in [0, 255]. out_embedded is 1 for such a pair and 0 otherwise.
- R3: For a transformable pair in which x and y are not both odd, bit 0 of out_x is 1 and bit 0 of out_y is the next watermark bit.
- R4: For a transformable pair in which x and y are both odd, bit 0 of out_x is 0 and bit 0 of out_y is the next watermark bit.
- R5: For a pair that is not transformable, out_x is x with bit 0 cleared, out_y equals y, and out_aux carries the original bit 0 of x. For transformable pairs out_aux is 0.
- R6: A watermark bit is taken (wm_valid and wm_ready both high at a clock edge) once for each transformable pair, in stream order, and never for a pass-through pair.
- R7: A pair accepted at a clock edge appears on the output after the third rising edge, counting the accepting edge as the first, when nothing stalls. Every accepted pair comes out exactly once and in input order.
- R8: While out_valid is high and out_ready is low, all outputs hold their values and in_ready is low.
- R9: A transformable pair that reaches the insertion stage while wm_valid is low is held there with wm_ready high. It is released on the edge at which a bit is supplied.
- R10: During reset and right after it, out_valid and wm_ready are low. Once reset has been released and synchronised, in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block can accept a pair |
| in_x | input | 8 | First pixel of the pair |
| in_y | input | 8 | Second pixel of the pair |
| wm_valid | input | 1 | Watermark bit available |
| wm_ready | output | 1 | Watermark bit taken at this edge when wm_valid is high |
| wm_bit | input | 1 | Watermark payload bit |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Consumer accepts the output pair |
| out_x | output | 8 | Output first pixel |
| out_y | output | 8 | Output second pixel |
| out_embedded | output | 1 | Pair was transformed and carries a payload bit |
| out_aux | output | 1 | Original bit 0 of x for pass-through pairs, else 0 |

## Verification
Several properties are checked by assertions on every cycle. These are: stable outputs and a low in_ready while the output is blocked; a taken watermark bit always leading to an embedded pair on the next cycle; a cleared x bit 0 on pass-through outputs; and a zero auxiliary bit on embedded outputs. The arithmetic itself, the domain boundary and the branch between odd and non-odd pairs can only be shown by the bench. It sweeps all 65 536 pairs against an independent model under random stalls on both streams. The same holds for the payload order, the exact latency and the release of a pair held for a missing watermark bit, which the bench covers with directed scenarios.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

  // Branch taken for a pixel pair at the selection stage.
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,   // outside the gray-level domain
    MODE_EVEN = 2'd1,   // transformable, not both odd
    MODE_ODD  = 2'd2    // transformable, both odd
  } mode_e;

endpackage

// File: rtl/rcm_rst_sync.sv
module rcm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;

endmodule

// File: rtl/rcm_xform_stage.sv
// Stage 1: signed contrast map and domain test.
module rcm_xform_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_x,
  input  logic [PIX_W-1:0] in_y,
  output logic             s1_valid,
  output logic [PIX_W-1:0] s1_x,
  output logic [PIX_W-1:0] s1_y,
  output logic [PIX_W-1:0] s1_xt,
  output logic [PIX_W-1:0] s1_yt,
  output logic             s1_dom,
  output logic             s1_odd
);

  // Two guard bits: one for the doubling, one for the sign.
  localparam int WIDE = PIX_W + 2;

  logic signed [WIDE-1:0] xs_w, ys_w, xt_w, yt_w;
  logic                   xt_ok, yt_ok;
  logic                   dom_d, odd_d;

  always_comb begin
    xs_w  = $signed({2'b00, in_x});
    ys_w  = $signed({2'b00, in_y});
    xt_w  = xs_w + xs_w - ys_w;
    yt_w  = ys_w + ys_w - xs_w;
    // In range: non-negative and no bit set above the pixel width.
    xt_ok = (xt_w[WIDE-1:PIX_W] == 2'b00);
    yt_ok = (yt_w[WIDE-1:PIX_W] == 2'b00);
    dom_d = xt_ok && yt_ok;
    odd_d = in_x[0] && in_y[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_x     <= '0;
      s1_y     <= '0;
      s1_xt    <= '0;
      s1_yt    <= '0;
      s1_dom   <= 1'b0;
      s1_odd   <= 1'b0;
    end else if (en) begin
      s1_valid <= in_valid;
      s1_x     <= in_x;
      s1_y     <= in_y;
      s1_xt    <= xt_w[PIX_W-1:0];
      s1_yt    <= yt_w[PIX_W-1:0];
      s1_dom   <= dom_d;
      s1_odd   <= odd_d;
    end
  end

endmodule

// File: rtl/rcm_branch_stage.sv
// Stage 2: choose pass-through, non-odd or odd-odd handling.
module rcm_branch_stage
  import rcm_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             s1_valid,
  input  logic [PIX_W-1:0] s1_x,
  input  logic [PIX_W-1:0] s1_y,
  input  logic [PIX_W-1:0] s1_xt,
  input  logic [PIX_W-1:0] s1_yt,
  input  logic             s1_dom,
  input  logic             s1_odd,
  output logic             s2_valid,
  output mode_e            s2_mode,
  output logic [PIX_W-1:0] s2_x,
  output logic [PIX_W-1:0] s2_y,
  output logic             s2_aux
);

  mode_e            mode_d;
  logic [PIX_W-1:0] x_d, y_d;
  logic             aux_d;

  always_comb begin
    if (!s1_dom)     mode_d = MODE_PASS;
    else if (s1_odd) mode_d = MODE_ODD;
    else             mode_d = MODE_EVEN;

    unique case (mode_d)
      MODE_EVEN: begin
        x_d   = {s1_xt[PIX_W-1:1], 1'b1};
        y_d   = s1_yt;
        aux_d = 1'b0;
      end
      MODE_ODD: begin
        x_d   = {s1_xt[PIX_W-1:1], 1'b0};
        y_d   = s1_yt;
        aux_d = 1'b0;
      end
      default: begin
        x_d   = {s1_x[PIX_W-1:1], 1'b0};
        y_d   = s1_y;
        aux_d = s1_x[0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_mode  <= MODE_PASS;
      s2_x     <= '0;
      s2_y     <= '0;
      s2_aux   <= 1'b0;
    end else if (en) begin
      s2_valid <= s1_valid;
      s2_mode  <= mode_d;
      s2_x     <= x_d;
      s2_y     <= y_d;
      s2_aux   <= aux_d;
    end
  end

endmodule

// File: rtl/rcm_lsb_stage.sv
// Stage 3: payload insertion and output register.
module rcm_lsb_stage
  import rcm_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ld_valid,
  input  mode_e            s2_mode,
  input  logic [PIX_W-1:0] s2_x,
  input  logic [PIX_W-1:0] s2_y,
  input  logic             s2_aux,
  input  logic             wm_bit,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_x,
  output logic [PIX_W-1:0] out_y,
  output logic             out_embedded,
  output logic             out_aux
);

  logic             emb_d;
  logic [PIX_W-1:0] y_d;

  always_comb begin
    emb_d = (s2_mode != MODE_PASS);
    y_d   = emb_d ? {s2_y[PIX_W-1:1], wm_bit} : s2_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_x        <= '0;
      out_y        <= '0;
      out_embedded <= 1'b0;
      out_aux      <= 1'b0;
    end else if (en) begin
      out_valid    <= ld_valid;
      out_x        <= s2_x;
      out_y        <= y_d;
      out_embedded <= emb_d;
      out_aux      <= s2_aux;
    end
  end

  // R8: a blocked output holds every field
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)
                                   && $stable(out_embedded) && $stable(out_aux)));

endmodule

// File: rtl/rcm_pair_embed.sv
module rcm_pair_embed
  import rcm_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_x,
  input  logic [PIX_W-1:0] in_y,
  input  logic             wm_valid,
  output logic             wm_ready,
  input  logic             wm_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_x,
  output logic [PIX_W-1:0] out_y,
  output logic             out_embedded,
  output logic             out_aux
);

  logic             rst_sn;
  logic             s1_valid, s1_dom, s1_odd;
  logic [PIX_W-1:0] s1_x, s1_y, s1_xt, s1_yt;
  logic             s2_valid, s2_aux;
  mode_e            s2_mode;
  logic [PIX_W-1:0] s2_x, s2_y;
  logic             s2_need, wm_ok, en_out, en_front, ld_out;

  rcm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  // Output stage advances when empty or drained. Front stages additionally
  // wait for a watermark bit when the pair in stage 2 needs one.
  always_comb begin
    s2_need  = s2_valid && (s2_mode != MODE_PASS);
    wm_ok    = !s2_need || wm_valid;
    en_out   = !out_valid || out_ready;
    en_front = en_out && wm_ok;
    ld_out   = s2_valid && wm_ok;
    in_ready = en_front;
    wm_ready = s2_need && en_out;
  end

  rcm_xform_stage #(.PIX_W(PIX_W)) u_xform (
    .clk      (clk),
    .rst_n    (rst_sn),
    .en       (en_front),
    .in_valid (in_valid),
    .in_x     (in_x),
    .in_y     (in_y),
    .s1_valid (s1_valid),
    .s1_x     (s1_x),
    .s1_y     (s1_y),
    .s1_xt    (s1_xt),
    .s1_yt    (s1_yt),
    .s1_dom   (s1_dom),
    .s1_odd   (s1_odd)
  );

  rcm_branch_stage #(.PIX_W(PIX_W)) u_branch (
    .clk      (clk),
    .rst_n    (rst_sn),
    .en       (en_front),
    .s1_valid (s1_valid),
    .s1_x     (s1_x),
    .s1_y     (s1_y),
    .s1_xt    (s1_xt),
    .s1_yt    (s1_yt),
    .s1_dom   (s1_dom),
    .s1_odd   (s1_odd),
    .s2_valid (s2_valid),
    .s2_mode  (s2_mode),
    .s2_x     (s2_x),
    .s2_y     (s2_y),
    .s2_aux   (s2_aux)
  );

  rcm_lsb_stage #(.PIX_W(PIX_W)) u_lsb (
    .clk          (clk),
    .rst_n        (rst_sn),
    .en           (en_out),
    .ld_valid     (ld_out),
    .s2_mode      (s2_mode),
    .s2_x         (s2_x),
    .s2_y         (s2_y),
    .s2_aux       (s2_aux),
    .wm_bit       (wm_bit),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_x        (out_x),
    .out_y        (out_y),
    .out_embedded (out_embedded),
    .out_aux      (out_aux)
  );

  // R6: every taken watermark bit shows up in an embedded pair next cycle
  p_wm_embed_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (wm_valid && wm_ready) |=> (out_valid && out_embedded));

  // R5: pass-through pairs leave with bit 0 of x cleared
  p_pass_lsb_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_embedded) |-> !out_x[0]);

  // R5: auxiliary bit is zero for transformed pairs
  p_aux_zero_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && out_embedded) |-> !out_aux);

  // R8: a blocked output refuses new input
  p_in_block_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/sim_rcm_pair_embed.sv
module sim_rcm_pair_embed;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready;
  logic [7:0] in_x, in_y;
  logic       wm_valid, wm_ready, wm_bit;
  logic       out_valid, out_ready;
  logic [7:0] out_x, out_y;
  logic       out_embedded, out_aux;

  int checks = 0;
  int fails  = 0;
  bit timeout = 0;

  always #4 clk = ~clk;   // 125 MHz

  rcm_pair_embed u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y),
    .wm_valid(wm_valid), .wm_ready(wm_ready), .wm_bit(wm_bit),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_embedded(out_embedded), .out_aux(out_aux)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Deterministic payload bit for stream index k.
  function automatic bit wmf(input int k);
    int unsigned h;
    h = k * 32'h9E3779B1;
    return h[17] ^ h[5];
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    timeout = 1;
  end

  initial begin
    int n_in, n_out, k_drv, k_exp, n_emb;
    bit stall_prev;
    logic [7:0] sx, sy;
    logic se, sa;
    rst_n = 1'b0; in_valid = 0; in_x = 0; in_y = 0;
    wm_valid = 0; wm_bit = 0; out_ready = 0;

    // R10: reset state
    repeat (3) step();
    chk(out_valid == 0, "R10 out_valid in reset", out_valid, 0);
    chk(wm_ready == 0, "R10 wm_ready in reset", wm_ready, 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk(out_valid == 0, "R10 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R10 in_ready after reset", in_ready, 1);

    // R7: latency, pair (10,10) -> x' 10 -> 11, y' 10 with bit 1 -> 11 (R3)
    out_ready = 1; wm_valid = 1; wm_bit = 1;
    in_valid = 1; in_x = 8'd10; in_y = 8'd10;
    step(); in_valid = 0;
    chk(out_valid == 0, "R7 not yet after edge 1", out_valid, 0);
    step();
    chk(out_valid == 0, "R7 not yet after edge 2", out_valid, 0);
    step();
    chk(out_valid == 1, "R7 valid after edge 3", out_valid, 1);
    chk(out_x == 8'd11, "R3 directed x", out_x, 11);
    chk(out_y == 8'd11, "R3 directed y", out_y, 11);
    wm_valid = 0;
    repeat (3) step();

    // R6/R5: pass pair (255,0) flows without watermark: x 254, y 0, aux 1
    in_valid = 1; in_x = 8'd255; in_y = 8'd0;
    step(); in_valid = 0;
    chk(wm_ready == 0, "R6 no bit asked for pass pair", wm_ready, 0);
    step(); step();
    chk(out_valid == 1 && out_embedded == 0, "R5 pass pair out", {out_valid, out_embedded}, 2);
    chk(out_x == 8'd254 && out_y == 8'd0 && out_aux == 1, "R5 pass fields",
        {out_x, out_y, 7'd0, out_aux}, {8'd254, 8'd0, 8'd1});

    // R9: transformable pair (20,20) starves for a watermark bit
    in_valid = 1; in_x = 8'd20; in_y = 8'd20;
    step(); in_valid = 0;
    repeat (5) step();
    chk(out_valid == 0, "R9 held pair not output", out_valid, 0);
    chk(wm_ready == 1, "R9 wm_ready while held", wm_ready, 1);
    chk(in_ready == 0, "R9 in_ready low while held", in_ready, 0);
    wm_valid = 1; wm_bit = 0;
    step(); wm_valid = 0;
    chk(out_valid == 1 && out_x == 8'd21 && out_y == 8'd20, "R9 released pair",
        {out_valid, out_x, out_y}, {1'b1, 8'd21, 8'd20});
    repeat (3) step();

    // Full sweep of all pairs with random stalls on every stream
    n_in = 0; n_out = 0; k_drv = 0; k_exp = 0; n_emb = 0; stall_prev = 0;
    sx = 0; sy = 0; se = 0; sa = 0;
    while (n_out < 65536 && !timeout) begin
      @(posedge clk); #1;
      in_valid  = (n_in < 65536) && ($urandom_range(15) != 0);
      in_x      = n_in[15:8];
      in_y      = n_in[7:0];
      out_ready = ($urandom_range(7) != 0);
      wm_valid  = ($urandom_range(7) != 0);
      wm_bit    = wmf(k_drv);
      #5;
      if (stall_prev) begin
        chk(out_valid && out_x == sx && out_y == sy && out_embedded == se && out_aux == sa,
            "R8 hold while blocked", {out_valid, out_x, out_y}, {1'b1, sx, sy});
      end
      if (in_valid && in_ready) n_in++;
      if (wm_valid && wm_ready) k_drv++;
      if (out_valid && out_ready) begin
        int x, y, xt, yt;
        bit dom, odd;
        x = n_out >> 8; y = n_out & 255;
        xt = 2 * x - y; yt = 2 * y - x;
        dom = (xt >= 0) && (xt <= 255) && (yt >= 0) && (yt <= 255);
        odd = x[0] && y[0];
        chk(out_embedded == dom, "R2 domain flag", out_embedded, dom);
        if (dom) begin
          chk(out_x[7:1] == xt[7:1] && out_y[7:1] == yt[7:1], "R1 transform bits",
              {out_x, out_y}, {xt[7:0], yt[7:0]});
          if (odd)
            chk(out_x[0] == 0, "R4 odd-odd x bit0", out_x[0], 0);
          else
            chk(out_x[0] == 1, "R3 non-odd x bit0", out_x[0], 1);
          chk(out_y[0] == wmf(k_exp), "R6 payload order in y bit0", out_y[0], wmf(k_exp));
          chk(out_aux == 0, "R5 aux zero when embedded", out_aux, 0);
          k_exp++; n_emb++;
        end else begin
          chk(out_x == {x[7:1], 1'b0} && out_y == y[7:0] && out_aux == x[0],
              "R5 pass-through", {out_x, out_y, 7'd0, out_aux}, {x[7:1], 1'b0, y[7:0], 7'd0, x[0]});
        end
        n_out++;
      end
      stall_prev = out_valid && !out_ready;
      sx = out_x; sy = out_y; se = out_embedded; sa = out_aux;
    end
    in_valid = 0;
    chk(!timeout, "R7 sweep finished before watchdog", timeout, 0);
    chk(n_out == 65536, "R7 all pairs out", n_out, 65536);
    chk(k_drv == n_emb, "R6 bits taken equal embedded pairs", k_drv, n_emb);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule